// File: doc/BRIEF.md
# GPIO Pin Override Control Cell

This block holds the per-pin control logic for a group of general-purpose digital I/O pins. Each pin normally behaves according to its direction bit and its port data bit, with a global pull-up disable shared by every pin. Peripherals that borrow a pin can take over each of its four control paths on their own. Those paths are the pull-up, the output driver enable, the driven value and the digital input enable. Each path has its own pair of override signals: an enable and a value.

The pad is modelled as three outputs per pin: drive enable, drive value and pull-up enable. On the input side, a disabled input is clamped to 0. By default the input is disabled while the sleep request is high. The clamped value feeds two paths. The first is an unsynchronized tap for peripherals, which supply their own synchronizers. The second is a two-flip-flop synchronizer that gives the value software reads. Because the clamp sits in front of both paths, a pin held high through sleep shows a rising edge when sleep ends.

Top module: `gpio_ovr_cell`

## Requirements
- R1: With the pull-up override enable low, padPullEn is 1 only when dirReg=0, portReg=1 and pullDisable=0. For the other seven combinations it is 0.
- R2: With the pull-up override enable high, padPullEn equals the pull-up override value. The direction, port and disable bits have no effect on it.
- R3: padDriveEn equals the direction override value while the direction override enable is high. Otherwise it equals dirReg.
- R4: While padDriveEn is 1, padDriveVal equals the port-value override value if that override's enable is high, and portReg if it is low. While padDriveEn is 0, padDriveVal is 0.
- R5: The digital input is enabled as follows. While the input-enable override enable is high, the input is enabled exactly when the override value is 1. While that enable is low, the input is enabled exactly when sleepReq is 0.
- R6: periphIn equals padIn in the same cycle while the input is enabled, and is 0 while it is disabled.
- R7: pinSync shows the clamped input exactly two rising clock edges after it changes. It is 0 during reset.
- R8: Take a pin with padIn held at 1, its input-enable override enable low and sleepReq high. When sleepReq falls, periphIn rises from 0 to 1, and two edges later pinSync rises too.
- R9: When the direction override enable and value are both 1 and the port-value override enable is 1, the pin drives the port-value override value. Both dirReg and portReg are then ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock for the synchronizer |
| rstN | input | 1 | Active-low asynchronous reset |
| dirReg | input | NUM_PINS | Direction register bits, 1 = output |
| portReg | input | NUM_PINS | Port data register bits |
| pullDisable | input | 1 | Global pull-up disable |
| sleepReq | input | 1 | Sleep request, disables inputs by default |
| puOvEn | input | NUM_PINS | Pull-up override enable |
| puOvVal | input | NUM_PINS | Pull-up override value |
| ddOvEn | input | NUM_PINS | Direction override enable |
| ddOvVal | input | NUM_PINS | Direction override value |
| pvOvEn | input | NUM_PINS | Port-value override enable |
| pvOvVal | input | NUM_PINS | Port-value override value |
| dieOvEn | input | NUM_PINS | Input-enable override enable |
| dieOvVal | input | NUM_PINS | Input-enable override value |
| padIn | input | NUM_PINS | Level seen at the pad |
| padDriveEn | output | NUM_PINS | Output driver enable |
| padDriveVal | output | NUM_PINS | Output driver value |
| padPullEn | output | NUM_PINS | Pull-up enable |
| periphIn | output | NUM_PINS | Clamped, unsynchronized input for peripherals |
| pinSync | output | NUM_PINS | Synchronized input for register reads |

## Verification
The three pad outputs and periphIn are combinational, so the bench checks them one nanosecond after it changes the inputs, with no clock edge in between. pinSync has two flops in its path. After changing padIn or the clamp, the bench steps one rising edge and confirms the old value is still there, then steps a second edge and expects the new value. Every sample is taken one nanosecond after an edge, well away from the edge itself. For the wake-from-sleep edge, the bench checks periphIn in the same cycle that sleep is released and checks pinSync two edges later.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;

  // Strobes from the control decode to the pad/input datapath, one per pin
  typedef struct packed {
    logic driveEn;
    logic driveVal;
    logic pullEn;
    logic inEn;
  } pin_strobe_t;

endpackage

// File: rtl/gpio_ovr_ctrl.sv
module gpio_ovr_ctrl
  import gpio_ovr_pkg::*;
#(
  parameter int NUM_PINS = 4
) (
  input  logic [NUM_PINS-1:0] dirReg,
  input  logic [NUM_PINS-1:0] portReg,
  input  logic                pullDisable,
  input  logic                sleepReq,
  input  logic [NUM_PINS-1:0] puOvEn,
  input  logic [NUM_PINS-1:0] puOvVal,
  input  logic [NUM_PINS-1:0] ddOvEn,
  input  logic [NUM_PINS-1:0] ddOvVal,
  input  logic [NUM_PINS-1:0] pvOvEn,
  input  logic [NUM_PINS-1:0] pvOvVal,
  input  logic [NUM_PINS-1:0] dieOvEn,
  input  logic [NUM_PINS-1:0] dieOvVal,
  output pin_strobe_t [NUM_PINS-1:0] strobes
);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic pullNatural;
    logic driveOn;
    logic valueSel;

    always_comb begin
      // Register-driven pull-up: input, port bit high, pull-ups not globally off
      pullNatural = !dirReg[p] && portReg[p] && !pullDisable;
      driveOn     = ddOvEn[p] ? ddOvVal[p] : dirReg[p];
      valueSel    = pvOvEn[p] ? pvOvVal[p] : portReg[p];

      strobes[p].pullEn   = puOvEn[p] ? puOvVal[p] : pullNatural;
      strobes[p].driveEn  = driveOn;
      strobes[p].driveVal = driveOn && valueSel;
      strobes[p].inEn     = dieOvEn[p] ? dieOvVal[p] : !sleepReq;
    end
  end

  // R4: an idle driver never presents a high value
  always_comb begin
    for (int p = 0; p < NUM_PINS; p++) begin
      a_r4_idle_value_low: assert (strobes[p].driveEn || !strobes[p].driveVal);
    end
  end

endmodule

// File: rtl/gpio_ovr_dp.sv
module gpio_ovr_dp
  import gpio_ovr_pkg::*;
#(
  parameter int NUM_PINS    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  pin_strobe_t [NUM_PINS-1:0] strobes,
  input  logic [NUM_PINS-1:0]        padIn,
  output logic [NUM_PINS-1:0]        padDriveEn,
  output logic [NUM_PINS-1:0]        padDriveVal,
  output logic [NUM_PINS-1:0]        padPullEn,
  output logic [NUM_PINS-1:0]        periphIn,
  output logic [NUM_PINS-1:0]        pinSync
);

  localparam int LAST_STAGE = SYNC_STAGES - 1;

  logic [NUM_PINS-1:0] clampedIn;
  logic [NUM_PINS-1:0] inEnVec;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [SYNC_STAGES-1:0] syncChain;

    always_comb begin
      padDriveEn[p]  = strobes[p].driveEn;
      padDriveVal[p] = strobes[p].driveVal;
      padPullEn[p]   = strobes[p].pullEn;
      inEnVec[p]     = strobes[p].inEn;
      // Clamp sits ahead of both the peripheral tap and the synchronizer
      clampedIn[p]   = padIn[p] && strobes[p].inEn;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncChain <= '0;
      end else begin
        syncChain <= {syncChain[SYNC_STAGES-2:0], clampedIn[p]};
      end
    end

    assign pinSync[p] = syncChain[LAST_STAGE];
  end

  assign periphIn = clampedIn;

  // Cycles since reset, saturating, so the latency check never looks before reset
  logic [1:0] rstAge;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rstAge <= '0;
    else if (rstAge != 2'd3) rstAge <= rstAge + 2'd1;
  end

  // R6: a disabled input reaches the peripherals as 0
  a_r6_clamp_zero: assert property (@(posedge clk) disable iff (!rstN)
    ((periphIn & ~inEnVec) == '0));

  // R7: register-visible value lags the clamped input by two edges
  if (SYNC_STAGES == 2) begin : g_lat_chk
    a_r7_sync_latency: assert property (@(posedge clk) disable iff (!rstN)
      (rstAge >= 2'd2) |-> (pinSync == $past(periphIn, 2)));
  end

endmodule

// File: rtl/gpio_ovr_cell.sv
module gpio_ovr_cell
  import gpio_ovr_pkg::*;
#(
  parameter int NUM_PINS    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] dirReg,
  input  logic [NUM_PINS-1:0] portReg,
  input  logic                pullDisable,
  input  logic                sleepReq,
  input  logic [NUM_PINS-1:0] puOvEn,
  input  logic [NUM_PINS-1:0] puOvVal,
  input  logic [NUM_PINS-1:0] ddOvEn,
  input  logic [NUM_PINS-1:0] ddOvVal,
  input  logic [NUM_PINS-1:0] pvOvEn,
  input  logic [NUM_PINS-1:0] pvOvVal,
  input  logic [NUM_PINS-1:0] dieOvEn,
  input  logic [NUM_PINS-1:0] dieOvVal,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padDriveEn,
  output logic [NUM_PINS-1:0] padDriveVal,
  output logic [NUM_PINS-1:0] padPullEn,
  output logic [NUM_PINS-1:0] periphIn,
  output logic [NUM_PINS-1:0] pinSync
);

  pin_strobe_t [NUM_PINS-1:0] strobes;

  gpio_ovr_ctrl #(.NUM_PINS(NUM_PINS)) ctrl_i (
    .dirReg(dirReg), .portReg(portReg), .pullDisable(pullDisable),
    .sleepReq(sleepReq), .puOvEn(puOvEn), .puOvVal(puOvVal),
    .ddOvEn(ddOvEn), .ddOvVal(ddOvVal), .pvOvEn(pvOvEn), .pvOvVal(pvOvVal),
    .dieOvEn(dieOvEn), .dieOvVal(dieOvVal), .strobes(strobes)
  );

  gpio_ovr_dp #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .padIn(padIn),
    .padDriveEn(padDriveEn), .padDriveVal(padDriveVal), .padPullEn(padPullEn),
    .periphIn(periphIn), .pinSync(pinSync)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_chk
    // R3: direction override takes the driver regardless of the register
    a_r3_dir_override: assert property (@(posedge clk) disable iff (!rstN)
      ddOvEn[p] |-> (padDriveEn[p] == ddOvVal[p]));

    // R9: full output override drives the override value
    a_r9_override_wins: assert property (@(posedge clk) disable iff (!rstN)
      (ddOvEn[p] && ddOvVal[p] && pvOvEn[p]) |-> (padDriveEn[p] && padDriveVal[p] == pvOvVal[p]));

    // R8: leaving sleep with the pad high yields a rising edge at the tap
    a_r8_wake_edge: assert property (@(posedge clk) disable iff (!rstN)
      ($fell(sleepReq) && !dieOvEn[p] && !$past(dieOvEn[p]) && padIn[p] && $past(padIn[p]))
      |-> $rose(periphIn[p]));
  end

endmodule

// File: tb/gpio_ovr_cell_tb_top.sv
module gpio_ovr_cell_tb_top;
  localparam int NP = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NP-1:0] dirReg = '0, portReg = '0;
  logic pullDisable = 1'b0, sleepReq = 1'b0;
  logic [NP-1:0] puOvEn = '0, puOvVal = '0, ddOvEn = '0, ddOvVal = '0;
  logic [NP-1:0] pvOvEn = '0, pvOvVal = '0, dieOvEn = '0, dieOvVal = '0;
  logic [NP-1:0] padIn = '0;
  logic [NP-1:0] padDriveEn, padDriveVal, padPullEn, periphIn, pinSync;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  gpio_ovr_cell #(.NUM_PINS(NP)) dut_i (
    .clk(clk), .rstN(rstN), .dirReg(dirReg), .portReg(portReg),
    .pullDisable(pullDisable), .sleepReq(sleepReq),
    .puOvEn(puOvEn), .puOvVal(puOvVal), .ddOvEn(ddOvEn), .ddOvVal(ddOvVal),
    .pvOvEn(pvOvEn), .pvOvVal(pvOvVal), .dieOvEn(dieOvEn), .dieOvVal(dieOvVal),
    .padIn(padIn), .padDriveEn(padDriveEn), .padDriveVal(padDriveVal),
    .padPullEn(padPullEn), .periphIn(periphIn), .pinSync(pinSync)
  );

  task automatic check(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic finish();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired");
      finish();
    end
  end

  initial begin
    // R7: reset state with the pad high and input enabled
    padIn = '1;
    tick(); tick(); tick();
    check("R7 reset value", pinSync, '0);
    rstN = 1'b1;
    padIn = '0;
    tick(); tick(); tick();

    // R1 R2 R3 R4 R9: sweep register bits and output-side overrides
    for (int c = 0; c < 512; c++) begin
      logic [NP-1:0] expPull, expEn, expVal;
      logic [8:0] s0;
      s0 = 9'(c);
      pullDisable = s0[2];
      for (int p = 0; p < NP; p++) begin
        logic [8:0] s;
        logic natPull, en, val;
        s = (p == 0) ? s0 : {s0[8:3] ^ 6'(p * 13), s0[2:0] ^ 3'(p)};
        s[2] = s0[2];
        dirReg[p] = s[0]; portReg[p] = s[1];
        puOvEn[p] = s[3]; puOvVal[p] = s[4];
        ddOvEn[p] = s[5]; ddOvVal[p] = s[6];
        pvOvEn[p] = s[7]; pvOvVal[p] = s[8];
        natPull = (s[2:0] == 3'b010) ? 1'b0 : 1'b0;
        natPull = (s[0] == 1'b0) && (s[1] == 1'b1) && (s[2] == 1'b0);
        expPull[p] = s[3] ? s[4] : natPull;
        en = s[5] ? s[6] : s[0];
        val = s[7] ? s[8] : s[1];
        expEn[p] = en;
        expVal[p] = en & val;
      end
      #1;
      if (puOvEn[0]) check("R2 pull override", padPullEn, expPull);
      else check("R1 pull from registers", padPullEn, expPull);
      check("R3 drive enable", padDriveEn, expEn);
      if (ddOvEn[0] && ddOvVal[0] && pvOvEn[0])
        check("R9 full override", padDriveVal, expVal);
      else
        check("R4 drive value", padDriveVal, expVal);
    end
    dirReg = '0; portReg = '0; pullDisable = 1'b0;
    puOvEn = '0; puOvVal = '0; ddOvEn = '0; ddOvVal = '0; pvOvEn = '0; pvOvVal = '0;

    // R5 R6: input enable and clamp over sleep and input-enable override
    for (int c = 0; c < 16; c++) begin
      logic [3:0] s;
      logic ie;
      s = 4'(c);
      sleepReq = s[0];
      dieOvEn = {NP{s[1]}};
      dieOvVal = {NP{s[2]}};
      padIn = s[3] ? 4'b1011 : 4'b0110;
      ie = s[1] ? s[2] : !s[0];
      #1;
      check("R5 R6 tap follows enable", periphIn, ie ? padIn : '0);
    end

    // R7: two-edge latency of the register-visible input
    sleepReq = 1'b0; dieOvEn = '0; dieOvVal = '0;
    padIn = 4'b0000;
    tick(); tick(); tick();
    check("R7 settled low", pinSync, 4'b0000);
    padIn = 4'b1010;
    tick();
    check("R7 one edge holds old", pinSync, 4'b0000);
    tick();
    check("R7 two edges shows new", pinSync, 4'b1010);
    padIn = 4'b0101;
    tick();
    check("R7 one edge holds old", pinSync, 4'b1010);
    tick();
    check("R7 two edges shows new", pinSync, 4'b0101);

    // R8: wake from sleep with the pad held high
    padIn = '1;
    sleepReq = 1'b1;
    #1;
    check("R8 clamped in sleep", periphIn, '0);
    tick(); tick(); tick();
    check("R8 sync low in sleep", pinSync, '0);
    sleepReq = 1'b0;
    #1;
    check("R8 tap rises on wake", periphIn, '1);
    tick();
    check("R8 sync one edge after wake", pinSync, '0);
    tick();
    check("R8 sync rises after wake", pinSync, '1);

    // R5: override keeps the input alive through sleep
    dieOvEn = 4'b0011; dieOvVal = 4'b0011;
    sleepReq = 1'b1;
    #1;
    check("R5 override beats sleep", periphIn, 4'b0011);
    sleepReq = 1'b0;
    dieOvVal = 4'b0000;
    #1;
    check("R5 override disables awake", periphIn, 4'b1100);

    finished = 1'b1;
    finish();
  end

endmodule